// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block keeps one load-locked reservation for each of a parameterized number of CPU ports sharing one memory. Every cycle, each port presents an operation code and a byte address. A load-locked records the cache line of its address for that CPU. A conditional store asks whether that CPU still holds the reservation. The block answers one cycle later with a status bit for the destination register (1 on success, 0 on failure) and a write-enable that is raised only when the conditional store wins.

All committed stores are snooped against every reservation at cache-line granularity. A committed store is a plain store from any port or a winning conditional store. A CPU also loses its own reservation when it executes a barrier, enters a privileged call, takes a fault or issues any conditional store. When several conditional stores aim at the same line in one cycle, a round-robin pointer picks exactly one winner per line. The pointer then moves past the winner, so no port can be starved.

Each CPU slot is a two-state machine. RS_EMPTY has one exit, ACQUIRE, taken on a load-locked. RS_HELD takes one of four transitions. RENEW is a new load-locked and stays in RS_HELD. CONSUME is any conditional store from that CPU. FLUSH is a barrier, privileged call or fault. SNOOP_KILL is a committed store to the held line. CONSUME, FLUSH and SNOOP_KILL all return to RS_EMPTY.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no CPU holds a reservation and all outputs are 0, so a conditional store issued before any load-locked fails.
- R2: Operation codes per port are 0 idle, 1 load-locked, 2 conditional store, 3 plain store, 4 barrier, 5 privileged call and 6 fault. A conditional store to the reserved line, at any byte offset, with nothing intervening, raises sc_valid, sc_status and sc_we for that port in the cycle after it is presented.
- R3: A conditional store from a CPU with no reservation, or to a line other than the reserved one, returns sc_valid=1, sc_status=0, sc_we=0.
- R4: A plain store from any port, including the reserving CPU itself, to any byte of a reserved 64-byte line (address bits [5:0] ignored) clears that reservation.
- R5: Stores to a different line leave a reservation untouched.
- R6: A barrier, privileged call or fault clears only the issuing CPU's reservation.
- R7: Any conditional store clears the issuing CPU's reservation. A winning one also clears every other CPU's reservation on that line.
- R8: Among conditional stores in the same cycle that are eligible for one line, exactly one succeeds and the others fail.
- R9: The winner on a line is the first eligible port found from the round-robin pointer upwards. The pointer starts at 0 after reset and moves to one past the first winner in that order.
- R10: A new load-locked replaces the CPU's earlier reservation, so the old line no longer counts.
- R11: Stores snoop reservations as of the start of the cycle. A load-locked in the same cycle as another port's store to that line keeps its reservation, and a plain store in the same cycle does not change a conditional store's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_op | input | NCPU*3 | Operation code per port, port i in bits [3i+2:3i] |
| cpu_addr | input | NCPU*AW | Byte address per port, port i in bits [AW*i+AW-1:AW*i] |
| sc_valid | output | NCPU | One per port: a conditional store was answered |
| sc_status | output | NCPU | Destination register value of the conditional store |
| sc_we | output | NCPU | Memory write-enable, high only for a winning conditional store |

## Verification
The hardest situation to reach from the ports is contention in which several CPUs hold live reservations on one line and issue conditional stores in the same cycle. In the same cycles, stores and load-locks to that line arrive from other ports, and the round-robin pointer sits at a different position each time. Random stimulus draws addresses from only three lines with random byte offsets and weights load-locks and conditional stores heavily, so that situation recurs often. Directed rounds first give all ports a reservation on one line and then have them store conditionally together, once from each pointer position.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LL    = 3'd1,
        OP_SC    = 3'd2,
        OP_ST    = 3'd3,
        OP_BAR   = 3'd4,
        OP_PCALL = 3'd5,
        OP_FAULT = 3'd6,
        OP_RSVD  = 3'd7
    } cpu_op_e;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HELD  = 1'b1
    } resv_state_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot
    import llsc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int LW   = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      my_op,
    input  logic [LW-1:0]        my_line,
    input  logic [NCPU-1:0]      commit,
    input  logic [NCPU*LW-1:0]   commit_lines,
    output logic                 held,
    output logic [LW-1:0]        resv_line
);

    cpu_op_e     op;
    resv_state_e state_q, state_d;
    logic [LW-1:0] line_q, line_d;
    logic        snoop_hit;
    logic        flush_op;

    assign op       = cpu_op_e'(my_op);
    assign flush_op = (op == OP_BAR) || (op == OP_PCALL) || (op == OP_FAULT);

    // Committed stores from any port, own included, compared by line only
    always_comb begin
        snoop_hit = 1'b0;
        for (int j = 0; j < NCPU; j++) begin
            if (commit[j] && (commit_lines[j*LW +: LW] == line_q)) begin
                snoop_hit = 1'b1;
            end
        end
    end

    // Next-state logic: ACQUIRE, RENEW, CONSUME, FLUSH, SNOOP_KILL
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        unique case (state_q)
            RS_EMPTY: begin
                if (op == OP_LL) begin          // ACQUIRE
                    state_d = RS_HELD;
                    line_d  = my_line;
                end
            end
            RS_HELD: begin
                if (op == OP_LL) begin          // RENEW
                    line_d  = my_line;
                end else if (op == OP_SC) begin // CONSUME
                    state_d = RS_EMPTY;
                end else if (flush_op) begin    // FLUSH
                    state_d = RS_EMPTY;
                end else if (snoop_hit) begin   // SNOOP_KILL
                    state_d = RS_EMPTY;
                end
            end
            default: begin
                state_d = RS_EMPTY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
        end
    end

    // Outputs
    assign held      = (state_q == RS_HELD);
    assign resv_line = line_q;

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_op |=> (state_q == RS_EMPTY)); // R6

    AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HELD && snoop_hit && op != OP_LL) |=> (state_q == RS_EMPTY)); // R4

    AST_OTHER_LINE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HELD && !snoop_hit && (op == OP_IDLE || op == OP_ST))
        |=> (state_q == RS_HELD && $stable(line_q))); // R5

    AST_LL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LL) |=> (state_q == RS_HELD && line_q == $past(my_line))); // R10

endmodule

// File: rtl/llsc_sc_arbiter.sv
module llsc_sc_arbiter #(
    parameter int NCPU = 4,
    parameter int LW   = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCPU-1:0]      req,
    input  logic [NCPU*LW-1:0]   req_lines,
    output logic [NCPU-1:0]      grant
);

    localparam int PW = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [PW-1:0] ptr_q, ptr_d;

    function automatic int rank(input int idx, input int p);
        return (idx + NCPU - p) % NCPU;
    endfunction

    // Per-line winner: no eligible same-line port ranks ahead of it
    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            grant[i] = req[i];
            for (int j = 0; j < NCPU; j++) begin
                if (j != i && req[j] &&
                    req_lines[j*LW +: LW] == req_lines[i*LW +: LW] &&
                    rank(j, int'(ptr_q)) < rank(i, int'(ptr_q))) begin
                    grant[i] = 1'b0;
                end
            end
        end
    end

    // Pointer moves one past the first winner in round-robin order
    always_comb begin
        logic found;
        int   idx;
        found = 1'b0;
        ptr_d = ptr_q;
        for (int s = 0; s < NCPU; s++) begin
            idx = (int'(ptr_q) + s) % NCPU;
            if (!found && grant[idx]) begin
                found = 1'b1;
                ptr_d = PW'((idx + 1) % NCPU);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    AST_PTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr_q] |-> grant[ptr_q]); // R9

    for (genvar a = 0; a < NCPU; a++) begin : g_pair_a
        for (genvar b = a + 1; b < NCPU; b++) begin : g_pair_b
            AST_ONE_WINNER_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[a] && grant[b]) |-> (req_lines[a*LW +: LW] != req_lines[b*LW +: LW])); // R8
        end
    end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
    import llsc_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int AW        = 32,
    parameter int LINE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCPU*3-1:0]    cpu_op,
    input  logic [NCPU*AW-1:0]   cpu_addr,
    output logic [NCPU-1:0]      sc_valid,
    output logic [NCPU-1:0]      sc_status,
    output logic [NCPU-1:0]      sc_we
);

    localparam int LW = AW - LINE_BITS;

    cpu_op_e            ops      [NCPU];
    logic [LW-1:0]      lines    [NCPU];
    logic [LW-1:0]      rlines   [NCPU];
    logic [NCPU-1:0]    held;
    logic [NCPU-1:0]    eligible;
    logic [NCPU-1:0]    is_sc;
    logic [NCPU-1:0]    grant;
    logic [NCPU-1:0]    commit;
    logic [NCPU*LW-1:0] line_bus;

    for (genvar i = 0; i < NCPU; i++) begin : g_port
        assign ops[i]   = cpu_op_e'(cpu_op[i*OP_W +: OP_W]);
        assign lines[i] = cpu_addr[i*AW + LINE_BITS +: LW];
        assign line_bus[i*LW +: LW] = lines[i];

        assign is_sc[i]    = (ops[i] == OP_SC);
        assign eligible[i] = is_sc[i] && held[i] && (rlines[i] == lines[i]);
        assign commit[i]   = (ops[i] == OP_ST) || grant[i];

        llsc_resv_slot #(
            .NCPU (NCPU),
            .LW   (LW)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .my_op        (cpu_op[i*OP_W +: OP_W]),
            .my_line      (lines[i]),
            .commit       (commit),
            .commit_lines (line_bus),
            .held         (held[i]),
            .resv_line    (rlines[i])
        );

        AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
            is_sc[i] |=> !held[i]); // R7

        AST_WE_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            sc_we[i] |-> $past(held[i])); // R3
    end

    llsc_sc_arbiter #(
        .NCPU (NCPU),
        .LW   (LW)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .req_lines (line_bus),
        .grant     (grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_valid  <= '0;
            sc_status <= '0;
            sc_we     <= '0;
        end else begin
            sc_valid  <= is_sc;
            sc_status <= grant;
            sc_we     <= grant;
        end
    end

endmodule

// File: tb/tb_llsc_resv_monitor.sv
`timescale 1ns/1ps
module tb_llsc_resv_monitor;

    localparam int NCPU = 4;
    localparam int AW   = 32;
    localparam int LB   = 6;
    localparam int LW   = AW - LB;

    localparam logic [2:0] K_IDLE = 3'd0, K_LL = 3'd1, K_SC = 3'd2, K_ST = 3'd3,
                           K_BAR = 3'd4, K_PCALL = 3'd5, K_FAULT = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCPU*3-1:0]  cpu_op = '0;
    logic [NCPU*AW-1:0] cpu_addr = '0;
    logic [NCPU-1:0]    sc_valid, sc_status, sc_we;

    always #2.5 clk = ~clk;

    llsc_resv_monitor #(.NCPU(NCPU), .AW(AW), .LINE_BITS(LB)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .sc_valid(sc_valid), .sc_status(sc_status), .sc_we(sc_we)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0]    t_op [NCPU];
    logic [AW-1:0] t_ad [NCPU];

    bit            m_held [NCPU];
    logic [LW-1:0] m_line [NCPU];
    int            m_ptr;

    localparam logic [AW-1:0] LA = 32'h0000_1000;
    localparam logic [AW-1:0] LBX = 32'h0000_1040;
    localparam logic [AW-1:0] LC = 32'h0000_2000;

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        return a[AW-1:LB];
    endfunction

    function automatic int rank(input int idx, input int p);
        return (idx + NCPU - p) % NCPU;
    endfunction

    task automatic clear_ops();
        for (int i = 0; i < NCPU; i++) begin
            t_op[i] = K_IDLE;
            t_ad[i] = '0;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCPU; i++) begin
            m_held[i] = 0;
            m_line[i] = '0;
        end
        m_ptr = 0;
    endtask

    // One cycle: drive at negedge, expect registered answer at the next negedge
    task automatic run_cycle(input string tag);
        bit elig [NCPU];
        bit win  [NCPU];
        bit kill;
        bit found;
        logic [NCPU-1:0] ev, eo, ew;
        int idx;
        for (int i = 0; i < NCPU; i++)
            elig[i] = (t_op[i] == K_SC) && m_held[i] && (m_line[i] == line_of(t_ad[i]));
        for (int i = 0; i < NCPU; i++) begin
            win[i] = elig[i];
            for (int j = 0; j < NCPU; j++)
                if (j != i && elig[j] && line_of(t_ad[j]) == line_of(t_ad[i]) &&
                    rank(j, m_ptr) < rank(i, m_ptr))
                    win[i] = 0;
            ev[i] = (t_op[i] == K_SC);
            eo[i] = win[i];
            ew[i] = win[i];
        end
        for (int i = 0; i < NCPU; i++) begin
            cpu_op[i*3 +: 3]   = t_op[i];
            cpu_addr[i*AW +: AW] = t_ad[i];
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NCPU; i++) begin
            checks++;
            if (sc_valid[i] !== ev[i] || sc_status[i] !== eo[i] || sc_we[i] !== ew[i]) begin
                errors++;
                $display("FAIL %s cpu%0d valid/status/we actual %b%b%b expected %b%b%b",
                         tag, i, sc_valid[i], sc_status[i], sc_we[i], ev[i], eo[i], ew[i]);
            end
        end
        found = 0;
        for (int s = 0; s < NCPU; s++) begin
            idx = (m_ptr + s) % NCPU;
            if (!found && win[idx]) begin
                found = 1;
                m_ptr = (idx + 1) % NCPU;
            end
        end
        for (int k = 0; k < NCPU; k++) begin
            if (t_op[k] == K_LL) begin
                m_held[k] = 1;
                m_line[k] = line_of(t_ad[k]);
            end else if (t_op[k] == K_SC || t_op[k] == K_BAR ||
                         t_op[k] == K_PCALL || t_op[k] == K_FAULT) begin
                m_held[k] = 0;
            end else if (m_held[k]) begin
                kill = 0;
                for (int j = 0; j < NCPU; j++)
                    if ((t_op[j] == K_ST || win[j]) && line_of(t_ad[j]) == m_line[k])
                        kill = 1;
                if (kill) m_held[k] = 0;
            end
        end
        clear_ops();
    endtask

    task automatic put(input int c, input logic [2:0] o, input logic [AW-1:0] a);
        t_op[c] = o;
        t_ad[c] = a;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] flush_ops [3];
        logic [AW-1:0] pool [3];
        int r;
        flush_ops[0] = K_BAR; flush_ops[1] = K_PCALL; flush_ops[2] = K_FAULT;
        pool[0] = LA; pool[1] = LBX; pool[2] = LC;
        void'($urandom(32'd1234));
        clear_ops();
        model_reset();

        // R1: outputs during reset
        repeat (3) @(negedge clk);
        checks++;
        if (sc_valid !== '0 || sc_status !== '0 || sc_we !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b %b %b expected 0", sc_valid, sc_status, sc_we);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: conditional store with no reservation
        put(0, K_SC, LA); run_cycle("R1");

        // R2: offset-blind success
        put(1, K_LL, LA + 8); run_cycle("R2");
        run_cycle("R2");
        put(1, K_SC, LA + 32'h30); run_cycle("R2");

        // R3: wrong line fails
        put(2, K_LL, LA); run_cycle("R3");
        put(2, K_SC, LBX); run_cycle("R3");

        // R4: another port's store, then own store, to the line
        put(0, K_LL, LA); run_cycle("R4");
        put(3, K_ST, LA + 32'h3F); run_cycle("R4");
        put(0, K_SC, LA); run_cycle("R4");
        put(0, K_LL, LA); run_cycle("R4");
        put(0, K_ST, LA + 4); run_cycle("R4");
        put(0, K_SC, LA); run_cycle("R4");

        // R5: neighbouring line store leaves reservation
        put(0, K_LL, LA); run_cycle("R5");
        put(1, K_ST, LBX); put(2, K_ST, LC); run_cycle("R5");
        put(0, K_SC, LA + 2); run_cycle("R5");

        // R6: barrier, privileged call, fault clear only issuer
        for (int f = 0; f < 3; f++) begin
            put(0, K_LL, LA); put(1, K_LL, LA); run_cycle("R6");
            put(0, flush_ops[f], LC); run_cycle("R6");
            put(0, K_SC, LA); put(1, K_SC, LA); run_cycle("R6");
        end

        // R7: winner kills peers; failed store also consumes
        put(0, K_LL, LA); put(1, K_LL, LA); run_cycle("R7");
        put(0, K_SC, LA); run_cycle("R7");
        put(1, K_SC, LA); run_cycle("R7");
        put(2, K_LL, LA); run_cycle("R7");
        put(2, K_SC, LBX); run_cycle("R7");
        put(2, K_SC, LA); run_cycle("R7");

        // R8 and R9: full contention rounds rotate the winner
        for (int rnd = 0; rnd < 2 * NCPU; rnd++) begin
            for (int c = 0; c < NCPU; c++) put(c, K_LL, LA + 32'(c));
            run_cycle("R8");
            for (int c = 0; c < NCPU; c++) put(c, K_SC, LA + 32'(4 * c));
            run_cycle("R9");
        end
        // R8: two lines contended at once, one winner each
        put(0, K_LL, LA); put(1, K_LL, LA); put(2, K_LL, LC); put(3, K_LL, LC); run_cycle("R8");
        for (int c = 0; c < NCPU; c++) put(c, K_SC, (c < 2) ? LA : LC);
        run_cycle("R8");

        // R10: replacement
        put(0, K_LL, LA); run_cycle("R10");
        put(0, K_LL, LBX); run_cycle("R10");
        put(0, K_SC, LA); run_cycle("R10");
        put(0, K_LL, LA); run_cycle("R10");
        put(0, K_LL, LBX); run_cycle("R10");
        put(0, K_SC, LBX); run_cycle("R10");

        // R11: same-cycle ordering
        put(0, K_LL, LA); put(1, K_ST, LA); run_cycle("R11");
        put(0, K_SC, LA); run_cycle("R11");
        put(0, K_LL, LA); run_cycle("R11");
        put(0, K_SC, LA); put(1, K_ST, LA + 1); run_cycle("R11");

        // Random contention across three lines
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCPU; c++) begin
                r = $urandom_range(0, 99);
                t_ad[c] = pool[$urandom_range(0, 2)] + 32'($urandom_range(0, 63));
                if (r < 30)      t_op[c] = K_LL;
                else if (r < 60) t_op[c] = K_SC;
                else if (r < 72) t_op[c] = K_ST;
                else if (r < 76) t_op[c] = K_BAR;
                else if (r < 79) t_op[c] = K_PCALL;
                else if (r < 82) t_op[c] = K_FAULT;
                else             t_op[c] = K_IDLE;
            end
            run_cycle("R8 random");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule